// File: doc/BRIEF.md
# Domain-Tagged Return Address Stack

This block predicts return targets for a processor front end. Each call event pushes its return address onto a circular stack, and each return event pops the top entry and presents it as the predicted target one cycle later. Every entry records whether it was pushed while the core ran as host or as guest. A return only receives a prediction from an entry pushed in its own domain, so return addresses never cross the host/guest boundary.

The usable depth depends on the domain. The host always gets the full physical depth. A guest gets the full depth only when its allow-larger control bit is set. Otherwise it is held to the legacy 32 entries. The whole stack is emptied when an address-space register is written, on an implicit translation-cache invalidation, and on a context-identifier invalidation of any type other than single-address (type 0). A one-shot clear request bit empties the stack at the next guest entry and then drops by itself.

Top module: `domainRetStack`

## Requirements
- R1: After reset, predValid is 0, ctlOut is 0 and the stack holds no entries, so a return gets predValid=0.
- R2: sizeReport always shows FULL_DEPTH (64 by default) as an 8-bit value.
- R3: Return addresses pushed by calls come back last-in first-out. predValid=1 and predAddr appear in the cycle after the return event.
- R4: A return whose domain (guestMode, 1=guest) differs from the tag of the top entry gets predValid=0 and leaves the stack unchanged.
- R5: With guestMode=0 the active depth is FULL_DEPTH. Pushing past it overwrites the oldest entries, so exactly FULL_DEPTH of the newest addresses can be popped.
- R6: With guestMode=1 and control bit 0 (allow-larger) clear, the active depth is LEGACY_DEPTH (32). Only the 32 newest guest entries can be popped.
- R7: With guestMode=1 and control bit 0 set, the guest uses the full FULL_DEPTH.
- R8: When ctlLoad is high, ctlOut takes ctlIn in the next cycle (bit 0 allow-larger, bit 1 clear request). A guestEntry pulse with bit 1 set empties the stack and clears bit 1. A guestEntry pulse with bit 1 clear leaves the stack alone.
- R9: An asRegWrite pulse empties the stack.
- R10: An implicitInval pulse empties the stack.
- R11: A ctxInval pulse with ctxInvalType other than 0 empties the stack. With ctxInvalType 0 it has no effect.
- R12: When a flush and a call fall in the same cycle, the flush happens first. Afterwards the stack holds only the new address.
- R13: A return on an empty active region gives predValid=0.
- R14: When a call and a return fall in the same cycle, the return pops the entry that was on top before the call. The call's address is then pushed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| callValid | input | 1 | Call event: push callAddr |
| callAddr | input | ADDR_W | Return address to push |
| retValid | input | 1 | Return event: request a prediction |
| guestMode | input | 1 | Current domain, 1 = guest |
| guestEntry | input | 1 | Guest entry event pulse |
| asRegWrite | input | 1 | Address-space register write event |
| implicitInval | input | 1 | Implicit translation-cache invalidation event |
| ctxInval | input | 1 | Context-identifier invalidation event |
| ctxInvalType | input | 2 | Type of that invalidation; 0 = single address |
| ctlLoad | input | 1 | Load ctlIn into the control bits |
| ctlIn | input | 2 | Control bits: [0] allow-larger, [1] clear request |
| ctlOut | output | 2 | Current control bits |
| predValid | output | 1 | Prediction valid, one cycle after retValid |
| predAddr | output | ADDR_W | Predicted return address |
| sizeReport | output | 8 | Physical stack depth |

## Verification
The bench drives long push and pop sequences in every domain and depth setting, and works out each expected address arithmetically. A corrupted pointer or count shows up on the first pop after it: the wrong address comes back, or predValid is high or low when it should not be. A stale valid bit or wrong tag left behind by a flush or a domain switch shows up on the very next return, as a prediction where none is allowed. A wrong depth cap shows up only at the end of a deep drain, as one pop too many or too few.

// File: rtl/rasPkg.sv
package rasPkg;
  typedef struct packed {
    logic flush;
    logic push;
    logic popHit;
  } rasStrobe_t;
endpackage

// File: rtl/rasStore.sv
module rasStore
  import rasPkg::*;
#(
  parameter int FULL_DEPTH = 64,
  parameter int ADDR_W     = 32,
  localparam int PTR_W     = $clog2(FULL_DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  rasStrobe_t        strobe,
  input  logic [PTR_W-1:0]  wrIdx,
  input  logic [PTR_W-1:0]  rdIdx,
  input  logic [ADDR_W-1:0] callAddr,
  input  logic              guestMode,
  output logic              topValid,
  output logic              topTag,
  output logic [ADDR_W-1:0] predAddr
);
  logic [ADDR_W-1:0]     addrMem [FULL_DEPTH];
  logic [FULL_DEPTH-1:0] validMem;
  logic [FULL_DEPTH-1:0] tagMem;

  assign topValid = validMem[rdIdx];
  assign topTag   = tagMem[rdIdx];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validMem <= '0;
      tagMem   <= '0;
      predAddr <= '0;
      for (int i = 0; i < FULL_DEPTH; i++) addrMem[i] <= '0;
    end else begin
      if (strobe.flush) validMem <= '0;
      if (strobe.popHit) predAddr <= addrMem[rdIdx];
      if (strobe.push) begin
        addrMem[wrIdx]  <= callAddr;
        tagMem[wrIdx]   <= guestMode;
        validMem[wrIdx] <= 1'b1;
      end
    end
  end

  // R12
  flush_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.flush && !strobe.push) |=> (validMem == '0));

  // R3
  push_marks_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.push |=> (validMem[$past(wrIdx)] && tagMem[$past(wrIdx)] == $past(guestMode)));
endmodule

// File: rtl/rasCtrl.sv
module rasCtrl
  import rasPkg::*;
#(
  parameter int FULL_DEPTH   = 64,
  parameter int LEGACY_DEPTH = 32,
  localparam int PTR_W       = $clog2(FULL_DEPTH),
  localparam int CNT_W       = $clog2(FULL_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             callValid,
  input  logic             retValid,
  input  logic             guestMode,
  input  logic             guestEntry,
  input  logic             asRegWrite,
  input  logic             implicitInval,
  input  logic             ctxInval,
  input  logic [1:0]       ctxInvalType,
  input  logic             ctlLoad,
  input  logic [1:0]       ctlIn,
  input  logic             topValid,
  input  logic             topTag,
  output rasStrobe_t       strobe,
  output logic [PTR_W-1:0] wrIdx,
  output logic [PTR_W-1:0] rdIdx,
  output logic [1:0]       ctlOut,
  output logic             predValid
);
  localparam logic [CNT_W-1:0] FULL_C = CNT_W'(FULL_DEPTH);
  localparam logic [CNT_W-1:0] LEG_C  = CNT_W'(LEGACY_DEPTH);

  logic [PTR_W-1:0] tos, baseTos, midTos, nextTos;
  logic [CNT_W-1:0] cnt, baseCnt, effCnt, midCnt, nextCnt, activeDepth;
  logic [1:0]       ctlReg;
  logic             fullMode;

  assign ctlOut = ctlReg;

  always_comb begin
    fullMode    = !guestMode || ctlReg[0];
    activeDepth = fullMode ? FULL_C : LEG_C;
    strobe.flush = asRegWrite || implicitInval ||
                   (ctxInval && ctxInvalType != 2'd0) ||
                   (guestEntry && ctlReg[1]);
    baseTos = strobe.flush ? '0 : tos;
    baseCnt = strobe.flush ? '0 : cnt;
    effCnt  = (baseCnt > activeDepth) ? activeDepth : baseCnt;
    rdIdx   = baseTos - PTR_W'(1);
    strobe.popHit = retValid && (effCnt != '0) && topValid && (topTag == guestMode);
    midTos  = strobe.popHit ? rdIdx : baseTos;
    midCnt  = strobe.popHit ? effCnt - CNT_W'(1) : effCnt;
    strobe.push = callValid;
    wrIdx   = midTos;
    if (callValid) begin
      nextTos = midTos + PTR_W'(1);
      nextCnt = (midCnt >= activeDepth) ? activeDepth : midCnt + CNT_W'(1);
    end else if (strobe.popHit) begin
      nextTos = midTos;
      nextCnt = midCnt;
    end else begin
      nextTos = baseTos;
      nextCnt = baseCnt;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tos       <= '0;
      cnt       <= '0;
      ctlReg    <= '0;
      predValid <= 1'b0;
    end else begin
      tos       <= nextTos;
      cnt       <= nextCnt;
      predValid <= strobe.popHit;
      if (ctlLoad) ctlReg <= ctlIn;
      else if (guestEntry && ctlReg[1]) ctlReg[1] <= 1'b0;
    end
  end

  // R5
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= FULL_C);

  // R6
  guest_cap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (callValid && guestMode && !ctlReg[0]) |=> (cnt <= LEG_C));

  // R12
  flush_then_push_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.flush && callValid && !retValid) |=> (cnt == CNT_W'(1) && tos == PTR_W'(1)));

  // R8
  clear_autodrop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (guestEntry && ctlReg[1] && !ctlLoad) |=> !ctlReg[1]);

  // R3
  pred_after_ret_chk: assert property (@(posedge clk) disable iff (!rstN)
    predValid |-> $past(retValid));

  // R13
  empty_no_hit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (retValid && effCnt == '0) |=> !predValid);
endmodule

// File: rtl/domainRetStack.sv
module domainRetStack
  import rasPkg::*;
#(
  parameter int ADDR_W       = 32,
  parameter int FULL_DEPTH   = 64,
  parameter int LEGACY_DEPTH = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              callValid,
  input  logic [ADDR_W-1:0] callAddr,
  input  logic              retValid,
  input  logic              guestMode,
  input  logic              guestEntry,
  input  logic              asRegWrite,
  input  logic              implicitInval,
  input  logic              ctxInval,
  input  logic [1:0]        ctxInvalType,
  input  logic              ctlLoad,
  input  logic [1:0]        ctlIn,
  output logic [1:0]        ctlOut,
  output logic              predValid,
  output logic [ADDR_W-1:0] predAddr,
  output logic [7:0]        sizeReport
);
  localparam int PTR_W = $clog2(FULL_DEPTH);

  rasStrobe_t       strobe;
  logic [PTR_W-1:0] wrIdx, rdIdx;
  logic             topValid, topTag;

  assign sizeReport = 8'(FULL_DEPTH);

  rasCtrl #(.FULL_DEPTH(FULL_DEPTH), .LEGACY_DEPTH(LEGACY_DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .callValid(callValid), .retValid(retValid),
    .guestMode(guestMode), .guestEntry(guestEntry), .asRegWrite(asRegWrite),
    .implicitInval(implicitInval), .ctxInval(ctxInval), .ctxInvalType(ctxInvalType),
    .ctlLoad(ctlLoad), .ctlIn(ctlIn), .topValid(topValid), .topTag(topTag),
    .strobe(strobe), .wrIdx(wrIdx), .rdIdx(rdIdx), .ctlOut(ctlOut),
    .predValid(predValid)
  );

  rasStore #(.FULL_DEPTH(FULL_DEPTH), .ADDR_W(ADDR_W)) u_store (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrIdx(wrIdx), .rdIdx(rdIdx),
    .callAddr(callAddr), .guestMode(guestMode), .topValid(topValid),
    .topTag(topTag), .predAddr(predAddr)
  );
endmodule

// File: tb/domainRetStack_bench.sv
module domainRetStack_bench;
  localparam int AW = 32;
  localparam int FULL = 64;
  localparam int LEG = 32;

  logic clk = 1'b0, rstN = 1'b0;
  logic callValid = 0, retValid = 0, guestMode = 0, guestEntry = 0;
  logic asRegWrite = 0, implicitInval = 0, ctxInval = 0, ctlLoad = 0;
  logic [1:0] ctxInvalType = 0, ctlIn = 0, ctlOut;
  logic [AW-1:0] callAddr = 0, predAddr;
  logic predValid;
  logic [7:0] sizeReport;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  domainRetStack u_domainRetStack (
    .clk(clk), .rstN(rstN), .callValid(callValid), .callAddr(callAddr),
    .retValid(retValid), .guestMode(guestMode), .guestEntry(guestEntry),
    .asRegWrite(asRegWrite), .implicitInval(implicitInval), .ctxInval(ctxInval),
    .ctxInvalType(ctxInvalType), .ctlLoad(ctlLoad), .ctlIn(ctlIn),
    .ctlOut(ctlOut), .predValid(predValid), .predAddr(predAddr),
    .sizeReport(sizeReport)
  );

  function automatic logic [AW-1:0] pat(int i, int g);
    return 32'h4000_0000 + (g << 20) + i * 4;
  endfunction

  task automatic chk(bit ok, string req, logic [AW-1:0] act, logic [AW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
    callValid = 0; retValid = 0; guestEntry = 0; asRegWrite = 0;
    implicitInval = 0; ctxInval = 0; ctlLoad = 0; ctxInvalType = 0;
  endtask

  task automatic doCall(logic [AW-1:0] a);
    callValid = 1; callAddr = a; tick();
  endtask

  task automatic doRet(bit expV, logic [AW-1:0] expA, string req);
    retValid = 1; tick();
    chk(predValid == expV, req, AW'(predValid), AW'(expV));
    if (expV) chk(predAddr == expA, req, predAddr, expA);
  endtask

  task automatic flushAll();
    asRegWrite = 1; tick();
  endtask

  task automatic setCtl(logic [1:0] v);
    ctlLoad = 1; ctlIn = v; tick();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    // R1 / R2 reset state and size
    chk(predValid == 0, "R1", AW'(predValid), 0);
    chk(ctlOut == 0, "R1", AW'(ctlOut), 0);
    chk(sizeReport == 8'd64, "R2", AW'(sizeReport), 64);
    doRet(0, 0, "R1 R13 empty after reset");

    // R3 basic LIFO in host mode
    for (int i = 0; i < 5; i++) doCall(pat(i, 0));
    for (int i = 4; i >= 0; i--) doRet(1, pat(i, 0), "R3");
    doRet(0, 0, "R13");

    // R5 host overflow: 70 pushes keep newest 64
    for (int i = 0; i < 70; i++) doCall(pat(i, 0));
    for (int i = 69; i >= 6; i--) doRet(1, pat(i, 0), "R5");
    doRet(0, 0, "R5 beyond full depth");

    // R6 guest limited to legacy depth
    flushAll();
    guestMode = 1;
    for (int i = 0; i < 40; i++) doCall(pat(i, 1));
    for (int i = 39; i >= 8; i--) doRet(1, pat(i, 1), "R6");
    doRet(0, 0, "R6 beyond legacy depth");

    // R7 guest with allow-larger
    setCtl(2'b01);
    chk(ctlOut == 2'b01, "R8 load", AW'(ctlOut), 1);
    for (int i = 0; i < 40; i++) doCall(pat(i, 2));
    for (int i = 39; i >= 0; i--) doRet(1, pat(i, 2), "R7");
    doRet(0, 0, "R7 drained");
    setCtl(2'b00);

    // R4 domain tags
    flushAll();
    guestMode = 0; doCall(pat(1, 3));
    guestMode = 1; doCall(pat(2, 3));
    guestMode = 0; doRet(0, 0, "R4 host vs guest top");
    guestMode = 1; doRet(1, pat(2, 3), "R4 guest own entry");
    guestMode = 1; doRet(0, 0, "R4 guest vs host top");
    guestMode = 0; doRet(1, pat(1, 3), "R4 host own entry");

    // R8 clear request at guest entry
    for (int i = 0; i < 3; i++) doCall(pat(i, 4));
    setCtl(2'b10);
    chk(ctlOut == 2'b10, "R8 load", AW'(ctlOut), 2);
    guestEntry = 1; tick();
    chk(ctlOut == 2'b00, "R8 autoclear", AW'(ctlOut), 0);
    doRet(0, 0, "R8 flushed at entry");
    for (int i = 0; i < 2; i++) doCall(pat(i, 5));
    guestEntry = 1; tick();
    doRet(1, pat(1, 5), "R8 entry without request");

    // R9 and R10
    doCall(pat(7, 6)); asRegWrite = 1; tick();
    doRet(0, 0, "R9");
    doCall(pat(8, 6)); implicitInval = 1; tick();
    doRet(0, 0, "R10");

    // R11 all invalidation types
    for (int t = 0; t < 4; t++) begin
      flushAll();
      doCall(pat(t, 7));
      ctxInval = 1; ctxInvalType = 2'(t); tick();
      doRet(t == 0, pat(t, 7), "R11");
    end

    // R12 flush and push together
    flushAll();
    doCall(pat(1, 8));
    asRegWrite = 1; callValid = 1; callAddr = pat(2, 8); tick();
    doRet(1, pat(2, 8), "R12 new entry");
    doRet(0, 0, "R12 old entry gone");

    // R14 call and return together
    doCall(pat(1, 9));
    callValid = 1; callAddr = pat(2, 9); retValid = 1; tick();
    chk(predValid == 1, "R14", AW'(predValid), 1);
    chk(predAddr == pat(1, 9), "R14", predAddr, pat(1, 9));
    doRet(1, pat(2, 9), "R14 pushed after pop");
    doRet(0, 0, "R14 empty");

    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=%h expected=%h", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule